// File: doc/BRIEF.md
# Memory Front-End Sleep and Reset Controller

This block is the control front end of a parallel NOR-style memory. It watches the address bus, the active-low chip enable, output enable and write enable, and an active-low hardware reset pin. From these it decides when the device drops into a low-power automatic sleep state, when the data pads are driven, when a write strobe is taken as a command, and when the command state machine is forced back to array-read mode. It also tracks whether an embedded program or erase is in progress.

Sleep depends only on address stability. Once the address has been unchanged for an access time plus a guard interval, both counted in clock cycles, the block sleeps. The last data read stays latched on the outputs. Any address change wakes the block and captures fresh array data. The hardware reset pin is filtered by a minimum-width counter. Only a pulse that lasts long enough aborts a busy operation and returns the mode to array read. For the whole time the pin is low, however long, the pads are released and commands are refused. A ready flag returns one clock after the pin is released.

Top module: `memfe_ctrl`

## Requirements
- R1: With `hwrst_n` high, `asleep` goes high exactly `T_ACC_CYC + GUARD_CYC` clock edges after the edge that captured the last address change (the default is 20 edges).
- R2: Toggling `ce_n`, `oe_n` or `we_n` neither prevents nor ends sleep.
- R3: While `asleep` is high, `dq_out` holds the last captured data even if `array_data` changes.
- R4: An address change clears `asleep` at the next clock edge, and at that same edge `dq_out` takes the value of `array_data`.
- R5: The stability counter saturates, so `asleep` stays high for as long as the address stays unchanged and never falls back by wrapping around.
- R6: If `hwrst_n` is sampled low on `RST_MIN_CYC` consecutive edges, then at the last of those edges `mode` becomes 0 (array read). If the block was busy, `abort` is high for exactly one cycle.
- R7: A low pulse on `hwrst_n` that lasts fewer than `RST_MIN_CYC` edges leaves `mode` unchanged and raises no `abort`.
- R8: While `hwrst_n` is low, `dq_oe` is 0 and `cmd_accept` is 0.
- R9: `dq_oe` is 1 only when `ce_n` and `oe_n` are both low, `hwrst_n` is high and the block is not busy. In particular, `oe_n` high always gives `dq_oe` = 0.
- R10: `active` is high whenever `ce_n` is low or the block is busy, so deselecting the chip during a busy operation keeps it active.
- R11: `ready` is 0 while `hwrst_n` is low and rises one edge after release. A write strobe seen before `ready` is high is not accepted.
- R12: `mode` is encoded as 0 = array read, 1 = command, 2 = busy. A falling edge on `we_n` with `ce_n` low, `ready` high and `hwrst_n` high gives `cmd_accept` and moves mode 0 to 1. `op_start` moves mode 1 to 2, and `op_done` moves mode 2 to 0. `busy` is high when mode is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| addr | input | AW | Address bus |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| hwrst_n | input | 1 | Active-low hardware reset pin |
| op_start | input | 1 | Embedded program or erase begins |
| op_done | input | 1 | Embedded program or erase finished |
| array_data | input | DW | Data read from the array at `addr` |
| dq_out | output | DW | Latched output data |
| dq_oe | output | 1 | Data pad drive enable |
| cmd_accept | output | 1 | Write strobe accepted as a command |
| ready | output | 1 | Block ready for commands |
| asleep | output | 1 | Automatic sleep state |
| busy | output | 1 | Embedded operation in progress |
| active | output | 1 | Active (not standby) |
| abort | output | 1 | One-cycle pulse: a busy operation was aborted |
| mode | output | 2 | Command state machine mode |

## Verification
The hardest situation to reach is a reset pulse that lands on the boundary of the minimum width while an embedded operation is busy. The block must first be walked through a command strobe and `op_start` into busy mode. Then `hwrst_n` is held low for exactly one edge fewer than the minimum, which must leave busy mode intact, and afterwards for exactly the minimum, which must abort. Sleep holding is also awkward to observe. The stimulus lets the address settle past the limit, then changes the array data and toggles every control pin, and checks that the latched output and the sleep flag do not move.

// File: rtl/memfe_pkg.sv
package memfe_pkg;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_CMD  = 2'd1,
    MODE_BUSY = 2'd2
  } mode_e;

  // Number of stable-address cycles before sleep is entered.
  function automatic int sleep_limit(input int tacc_cyc, input int guard_cyc);
    return tacc_cyc + guard_cyc;
  endfunction

  // Output drive rule: pads driven only for a selected, enabled, idle device.
  function automatic logic pad_drive(input logic ce_n, input logic oe_n,
                                     input logic hwrst_n, input logic busy);
    return !ce_n && !oe_n && hwrst_n && !busy;
  endfunction

endpackage

// File: rtl/memfe_sleep_timer.sv
module memfe_sleep_timer #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int T_ACC_CYC = 14,
  parameter int GUARD_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          hwrst_n,
  input  logic [DW-1:0] array_data,
  output logic          asleep,
  output logic          addr_chg,
  output logic [DW-1:0] dq_out
);
  import memfe_pkg::*;

  localparam int LIM = sleep_limit(T_ACC_CYC, GUARD_CYC);
  localparam int CW  = $clog2(LIM + 1);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dq_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == CW'(LIM)) ? v : v + 1'b1;
  endfunction

  assign addr_chg = (addr != addr_q);
  assign asleep   = (cnt_q == CW'(LIM));
  assign dq_out   = dq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dq_q   <= '0;
    end else begin
      addr_q <= addr;
      if (addr_chg || !hwrst_n) cnt_q <= '0;
      else                      cnt_q <= sat_inc(cnt_q);
      if (addr_chg || !asleep)  dq_q  <= array_data;
    end
  end

endmodule

// File: rtl/memfe_rst_filter.sv
module memfe_rst_filter #(
  parameter int RST_MIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hwrst_n,
  output logic rst_hit,
  output logic ready
);
  localparam int RW = $clog2(RST_MIN_CYC + 1);

  logic [RW-1:0] low_cnt_q;
  logic          ready_q;

  assign rst_hit = !hwrst_n && (low_cnt_q == RW'(RST_MIN_CYC - 1));
  assign ready   = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      ready_q   <= 1'b1;
    end else begin
      ready_q <= hwrst_n;
      if (hwrst_n)                            low_cnt_q <= '0;
      else if (low_cnt_q != RW'(RST_MIN_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/memfe_mode_fsm.sv
module memfe_mode_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_accept,
  input  logic              op_start,
  input  logic              op_done,
  input  logic              rst_hit,
  output memfe_pkg::mode_e  mode,
  output logic              abort
);
  import memfe_pkg::*;

  mode_e mode_q, mode_d;
  logic  abort_q;

  always_comb begin
    mode_d = mode_q;
    if (rst_hit) begin
      mode_d = MODE_READ;
    end else begin
      unique case (mode_q)
        MODE_READ: if (cmd_accept) mode_d = MODE_CMD;
        MODE_CMD:  if (op_start)   mode_d = MODE_BUSY;
        MODE_BUSY: if (op_done)    mode_d = MODE_READ;
        default:                   mode_d = MODE_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_READ;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      abort_q <= rst_hit && (mode_q == MODE_BUSY);
    end
  end

  assign mode  = mode_q;
  assign abort = abort_q;

endmodule

// File: rtl/memfe_ctrl.sv
module memfe_ctrl #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int T_ACC_CYC   = 14,
  parameter int GUARD_CYC   = 6,
  parameter int RST_MIN_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          hwrst_n,
  input  logic          op_start,
  input  logic          op_done,
  input  logic [DW-1:0] array_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          cmd_accept,
  output logic          ready,
  output logic          asleep,
  output logic          busy,
  output logic          active,
  output logic          abort,
  output logic [1:0]    mode
);
  import memfe_pkg::*;

  logic  we_q;
  logic  we_fall;
  logic  rst_hit;
  logic  addr_chg;
  mode_e mode_e_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign we_fall    = we_q && !we_n;
  assign cmd_accept = we_fall && !ce_n && ready && hwrst_n;

  memfe_sleep_timer #(
    .AW(AW), .DW(DW), .T_ACC_CYC(T_ACC_CYC), .GUARD_CYC(GUARD_CYC)
  ) u_sleep (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .hwrst_n    (hwrst_n),
    .array_data (array_data),
    .asleep     (asleep),
    .addr_chg   (addr_chg),
    .dq_out     (dq_out)
  );

  memfe_rst_filter #(.RST_MIN_CYC(RST_MIN_CYC)) u_rstf (
    .clk     (clk),
    .rst_n   (rst_n),
    .hwrst_n (hwrst_n),
    .rst_hit (rst_hit),
    .ready   (ready)
  );

  memfe_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_accept (cmd_accept),
    .op_start   (op_start),
    .op_done    (op_done),
    .rst_hit    (rst_hit),
    .mode       (mode_e_w),
    .abort      (abort)
  );

  assign mode   = mode_e_w;
  assign busy   = (mode_e_w == MODE_BUSY);
  assign active = !ce_n || busy;
  assign dq_oe  = pad_drive(ce_n, oe_n, hwrst_n, busy);

endmodule

// File: rtl/memfe_ctrl_chk.sv
module memfe_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          ce_n,
  input logic          oe_n,
  input logic          hwrst_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic          cmd_accept,
  input logic          ready,
  input logic          asleep,
  input logic          busy,
  input logic          active,
  input logic          abort,
  input logic [1:0]    mode,
  input logic          rst_hit,
  input logic          addr_chg
);

  AST_NO_DRIVE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !hwrst_n |-> !dq_oe); // R8
  AST_NO_CMD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !hwrst_n |-> !cmd_accept); // R8
  AST_SLEEP_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |=> (!asleep || $stable(dq_out))); // R3
  AST_WAKE_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> !asleep); // R4
  AST_SLEEP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !addr_chg && hwrst_n) |=> asleep); // R5
  AST_RST_HIT_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hit |=> (mode == 2'd0)); // R6
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort); // R6
  AST_OE_HIGH_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R9
  AST_BUSY_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || ce_n) |-> !dq_oe); // R9
  AST_ACTIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> active); // R10
  AST_READY_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !hwrst_n |=> !ready); // R11
  AST_CMD_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> ready); // R11
  AST_ACCEPT_ENTERS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && mode == 2'd0 && !rst_hit) |=> (mode == 2'd1)); // R12

  wire unused_ok = &{1'b0, addr[0], ce_n};

endmodule

bind memfe_ctrl memfe_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .hwrst_n    (hwrst_n),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .cmd_accept (cmd_accept),
  .ready      (ready),
  .asleep     (asleep),
  .busy       (busy),
  .active     (active),
  .abort      (abort),
  .mode       (mode),
  .rst_hit    (rst_hit),
  .addr_chg   (addr_chg)
);

// File: tb/memfe_ctrl_bench.sv
`timescale 1ns/1ps
module memfe_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TACC = 14;
  localparam int GUARD = 6;
  localparam int RMIN = 8;
  localparam int LIM = TACC + GUARD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hwrst_n = 1'b1;
  logic op_start = 1'b0, op_done = 1'b0;
  logic [DW-1:0] mask = 16'hA5C3;
  logic [DW-1:0] array_data;
  logic [DW-1:0] dq_out;
  logic dq_oe, cmd_accept, ready, asleep, busy, active, abort;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  assign array_data = addr ^ mask;

  memfe_ctrl #(.AW(AW), .DW(DW), .T_ACC_CYC(TACC), .GUARD_CYC(GUARD),
               .RST_MIN_CYC(RMIN)) u_memfe_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .hwrst_n(hwrst_n), .op_start(op_start), .op_done(op_done),
    .array_data(array_data), .dq_out(dq_out), .dq_oe(dq_oe),
    .cmd_accept(cmd_accept), .ready(ready), .asleep(asleep), .busy(busy),
    .active(active), .abort(abort), .mode(mode)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // advance n edges, then sample 1 ns after the following negedge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset_state;
    chk("R11", "ready after reset", ready, 1);
    chk("R12", "mode after reset", mode, 0);
    chk("R9", "dq_oe after reset", dq_oe, 0);
    chk("R6", "abort after reset", abort, 0);
  endtask

  task automatic t_sleep_entry;   // R1, R5
    @(negedge clk); addr = 16'h1234;
    step(LIM);
    chk("R1", "not asleep one edge early", asleep, 0);
    step(1);
    chk("R1", "asleep at limit", asleep, 1);
    chk("R1", "data captured", dq_out, 16'h1234 ^ mask);
    step(3 * LIM);
    chk("R5", "still asleep, no wrap", asleep, 1);
  endtask

  task automatic t_sleep_controls; // R2, R3
    @(negedge clk); mask = 16'h0F0F;
    ce_n = 1'b0; oe_n = 1'b0;
    step(2);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b0;
    step(2);
    we_n = 1'b1;
    step(2);
    chk("R2", "controls do not wake", asleep, 1);
    chk("R3", "data held in sleep", dq_out, 16'h1234 ^ 16'hA5C3);
  endtask

  task automatic t_wake;           // R4
    @(negedge clk); addr = 16'h00FF;
    step(1);
    chk("R4", "woken after change", asleep, 0);
    chk("R4", "new data", dq_out, 16'h00FF ^ 16'h0F0F);
    mask = 16'hA5C3;
  endtask

  task automatic strobe_write;
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk); we_n = 1'b0; #1;
  endtask

  task automatic go_busy;
    strobe_write();
    @(negedge clk); we_n = 1'b1; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0; #1;
  endtask

  task automatic t_mode_flow;      // R12, R9, R10
    strobe_write();
    chk("R12", "write accepted", cmd_accept, 1);
    step(1);
    chk("R12", "mode command", mode, 1);
    we_n = 1'b1; oe_n = 1'b0;
    #0.5;
    chk("R9", "drive when selected and idle", dq_oe, 1);
    op_start = 1'b1;
    step(1);
    op_start = 1'b0;
    chk("R12", "mode busy", mode, 2);
    chk("R9", "no drive while busy", dq_oe, 0);
    oe_n = 1'b1; ce_n = 1'b1;
    #0.5;
    chk("R10", "active while busy and deselected", active, 1);
    op_done = 1'b1;
    step(1);
    op_done = 1'b0;
    chk("R12", "back to read", mode, 0);
    chk("R10", "standby when idle and deselected", active, 0);
    ce_n = 1'b0;
    #0.5;
    chk("R9", "oe_n high tristates", dq_oe, 0);
    ce_n = 1'b1;
  endtask

  task automatic t_short_reset;    // R7
    go_busy();
    chk("R12", "busy before short reset", mode, 2);
    @(negedge clk); hwrst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    step(RMIN - 1);
    chk("R8", "no drive in reset", dq_oe, 0);
    chk("R11", "not ready in reset", ready, 0);
    hwrst_n = 1'b1;
    #0.5;
    chk("R7", "short pulse keeps busy", mode, 2);
    step(1);
    chk("R7", "no abort on short pulse", abort, 0);
    op_done = 1'b1;
    step(1);
    op_done = 1'b0; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic t_long_reset;     // R6, R8, R11
    go_busy();
    @(negedge clk); hwrst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    step(RMIN - 1);
    chk("R6", "still busy one edge early", mode, 2);
    we_n = 1'b0;
    #0.5;
    chk("R8", "no command in reset", cmd_accept, 0);
    step(1);
    chk("R6", "mode read after min width", mode, 0);
    chk("R6", "abort pulse", abort, 1);
    chk("R8", "no drive in reset when idle", dq_oe, 0);
    we_n = 1'b1;
    step(1);
    chk("R6", "abort single cycle", abort, 0);
    hwrst_n = 1'b1; we_n = 1'b0;
    #0.5;
    chk("R11", "not ready at release", ready, 0);
    chk("R11", "write refused before ready", cmd_accept, 0);
    step(1);
    chk("R11", "ready one edge after release", ready, 1);
    chk("R11", "mode unchanged by early write", mode, 0);
    we_n = 1'b1;
    step(1);
    we_n = 1'b0;
    #0.5;
    chk("R11", "write accepted once ready", cmd_accept, 1);
    step(1);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset_state();
    t_sleep_entry();
    t_sleep_controls();
    t_wake();
    t_mode_flow();
    t_short_reset();
    t_long_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule